// File: doc/BRIEF.md
# Signed Deferred-Sign Sequential Array Multiplier

This block multiplies two 32-bit two's-complement numbers and returns the exact 64-bit signed product. It works one partial-product row at a time. It starts at the row of the second most significant multiplier bit and moves down toward bit 0. Rows whose multiplier bit is zero are skipped without spending a cycle. A priority search over the multiplier bits that are still pending picks the next row to add. That row is the multiplicand, sign-extended to 64 bits and shifted to the row's weight.

The row of the multiplier's sign bit is held back until every other row has been summed. In that last step it is subtracted when the sign bit is set, because its weight is -2^31. When the sign bit is clear, the step only moves the sum to the output. The latency therefore follows the number of ones in the low 31 multiplier bits:

- a zero multiplier finishes in one cycle;
- a multiplier of all ones needs 32 cycles.

A start strobe loads the operands, but only while the unit is idle. A one-cycle done pulse marks a new product. The product then stays on the output until the next operation completes.

Top module: `sgn_defer_mul`

## Requirements
- R1: After reset, done is 0, busy is 0 and product is 0.
- R2: start is taken only when busy is 0. A start raised while busy is 1 changes neither the running operation, its result nor its timing, and produces no extra done pulse.
- R3: The product equals the exact signed 64-bit product of the two 32-bit two's-complement operands captured at start.
- R4: Let start be sampled at clock edge E. Then done is high for the cycle that follows edge E+N, where N = 1 + (number of ones in multiplier bits 30..0). A zero multiplier gives N=1 and a multiplier of -1 gives N=32.
- R5: done lasts exactly one cycle, and busy is 0 whenever done is 1. product changes only in a cycle where done is 1 and holds its value otherwise.
- R6: When multiplier bit 31 is set, that row is weighted -2^31 times the multiplicand. This covers the most negative value times itself (result 2^62) and times -1 (result 2^31).
- R7: A start raised in the same cycle that done is high is accepted and starts the next operation immediately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Operation request, sampled while idle |
| mcand | input | 32 | Multiplicand, two's complement |
| mplier | input | 32 | Multiplier, two's complement |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: product is new |
| product | output | 64 | Signed product, held between completions |

## Verification
Completion and a new request can fall in the same cycle. done goes high in the cycle where busy has just dropped, and a waiting driver raises start in exactly that cycle. The scoreboard then expects the following operation to finish N cycles later with its own product. The bench also raises start while a 32-cycle operation is running. The scoreboard judges that case by the unchanged result and completion cycle of the running operation, and it counts any unexpected extra done pulse as a failure.

// File: rtl/sgn_defer_mul_pkg.sv
package sgn_defer_mul_pkg;
  typedef struct packed {
    logic load;      // capture operands, clear sum
    logic stepRow;   // add the highest pending non-sign row
    logic stepSign;  // apply the deferred sign row and publish
  } mulCtrlT;
endpackage

// File: rtl/lead_one_find.sv
module lead_one_find #(
  parameter int N  = 31,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (vec[i]) idx = IW'(i);
    end
    any = |vec;
  end
endmodule

// File: rtl/sgn_defer_mul_dp.sv
module sgn_defer_mul_dp
  import sgn_defer_mul_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  mulCtrlT            ctrl,
  input  logic [WIDTH-1:0]   mcand,
  input  logic [WIDTH-1:0]   mplier,
  output logic               anyLeft,
  output logic [2*WIDTH-1:0] product
);
  localparam int PW   = 2 * WIDTH;
  localparam int LOW  = WIDTH - 1;
  localparam int IDXW = $clog2(LOW);

  logic [PW-1:0]   mcandExt;
  logic [LOW-1:0]  pending;
  logic            signRow;
  logic [PW-1:0]   sumAcc;
  logic [IDXW-1:0] rowIdx;
  logic [PW-1:0]   rowAddend;
  logic [PW-1:0]   signTerm;

  lead_one_find #(.N(LOW), .IW(IDXW)) uFind (
    .vec (pending),
    .idx (rowIdx),
    .any (anyLeft)
  );

  // zero-row bypass: mux forces a zero addend when no row is flagged
  always_comb begin
    rowAddend = anyLeft ? (mcandExt << rowIdx) : '0;
    signTerm  = signRow ? (mcandExt << LOW) : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mcandExt <= '0;
      pending  <= '0;
      signRow  <= 1'b0;
      sumAcc   <= '0;
      product  <= '0;
    end else begin
      if (ctrl.load) begin
        mcandExt <= {{WIDTH{mcand[WIDTH-1]}}, mcand};
        pending  <= mplier[LOW-1:0];
        signRow  <= mplier[WIDTH-1];
        sumAcc   <= '0;
      end else if (ctrl.stepRow) begin
        sumAcc          <= sumAcc + rowAddend;
        pending[rowIdx] <= 1'b0;
      end
      if (ctrl.stepSign) begin
        product <= sumAcc - signTerm;
      end
    end
  end
endmodule

// File: rtl/sgn_defer_mul_ctl.sv
module sgn_defer_mul_ctl
  import sgn_defer_mul_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    anyLeft,
  output mulCtrlT ctrl,
  output logic    busy,
  output logic    done
);
  typedef enum logic {ST_IDLE, ST_RUN} stateT;
  stateT state;

  always_comb begin
    ctrl.load     = start && (state == ST_IDLE);
    ctrl.stepRow  = (state == ST_RUN) && anyLeft;
    ctrl.stepSign = (state == ST_RUN) && !anyLeft;
    busy          = (state == ST_RUN);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      done <= ctrl.stepSign;
      if (ctrl.load)          state <= ST_RUN;
      else if (ctrl.stepSign) state <= ST_IDLE;
    end
  end
endmodule

// File: rtl/sgn_defer_mul.sv
module sgn_defer_mul
  import sgn_defer_mul_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [WIDTH-1:0]   mcand,
  input  logic [WIDTH-1:0]   mplier,
  output logic               busy,
  output logic               done,
  output logic [2*WIDTH-1:0] product
);
  mulCtrlT ctrl;
  logic    anyLeft;

  sgn_defer_mul_ctl uCtl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .anyLeft (anyLeft),
    .ctrl    (ctrl),
    .busy    (busy),
    .done    (done)
  );

  sgn_defer_mul_dp #(.WIDTH(WIDTH)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .mcand   (mcand),
    .mplier  (mplier),
    .anyLeft (anyLeft),
    .product (product)
  );
endmodule

// File: rtl/sgn_defer_mul_chk.sv
module sgn_defer_mul_chk #(
  parameter int WIDTH = 32
) (
  input logic               clk,
  input logic               rstN,
  input logic               start,
  input logic [WIDTH-1:0]   mplier,
  input logic               busy,
  input logic               done,
  input logic [2*WIDTH-1:0] product
);
  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R5
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R5
  product_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(product) |-> done);

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  // R4
  zero_fast_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && mplier == '0) |-> ##2 done);

  // R4
  done_after_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(busy));
endmodule

bind sgn_defer_mul sgn_defer_mul_chk #(.WIDTH(WIDTH)) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .start   (start),
  .mplier  (mplier),
  .busy    (busy),
  .done    (done),
  .product (product)
);

// File: tb/tb_sgn_defer_mul.sv
`timescale 1ns/100ps
module tb_sgn_defer_mul;
  localparam int W = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [W-1:0]  mcand = '0;
  logic [W-1:0]  mplier = '0;
  logic          busy;
  logic          done;
  logic [63:0]   product;

  sgn_defer_mul #(.WIDTH(W)) dut (
    .clk(clk), .rstN(rstN), .start(start), .mcand(mcand), .mplier(mplier),
    .busy(busy), .done(done), .product(product)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    logic [63:0] prod;
    int          doneCyc;
    string       tag;
  } expT;

  expT  sbq[$];
  int   cycleCnt = 0;
  int   nChecks = 0;
  int   nFails = 0;
  bit   finished = 0;
  bit   monOn = 0;
  logic [63:0] lastProd = '0;
  logic        prevDone = 1'b0;

  always @(posedge clk) cycleCnt <= cycleCnt + 1;

  function automatic logic [63:0] refMul(logic [W-1:0] a, logic [W-1:0] b);
    logic signed [63:0] ea, eb;
    ea = {{32{a[W-1]}}, a};
    eb = {{32{b[W-1]}}, b};
    return ea * eb;
  endfunction

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // driver: waits for idle, raises start, pushes the expected item
  task automatic doOp(logic [W-1:0] a, logic [W-1:0] b, string tag);
    expT e;
    @(negedge clk);
    while (busy) @(negedge clk);
    mcand  = a;
    mplier = b;
    start  = 1'b1;
    e.prod    = refMul(a, b);
    e.doneCyc = cycleCnt + 1 + 1 + $countones(b[W-2:0]);
    e.tag     = tag;
    sbq.push_back(e);
    @(negedge clk);
    start = 1'b0;
  endtask

  // monitor: compares each done against the queue head
  always @(negedge clk) begin
    if (monOn) begin
      if (done && prevDone)
        check(1'b0, "R5", "done longer than one cycle", 64'd1, 64'd0);
      if (done && busy)
        check(1'b0, "R5", "busy during done", 64'd1, 64'd0);
      if (!done && product !== lastProd)
        check(1'b0, "R5", "product moved without done", product, lastProd);
      if (done) begin
        if (sbq.size() == 0) begin
          check(1'b0, "R2", "unexpected done", product, lastProd);
        end else begin
          expT e;
          e = sbq.pop_front();
          check(product === e.prod, e.tag, "product", product, e.prod);
          check(cycleCnt == e.doneCyc, "R4", {e.tag, " latency"},
                64'(cycleCnt), 64'(e.doneCyc));
        end
        lastProd = product;
      end
      prevDone = done;
    end
  end

  task automatic drain();
    int guard = 0;
    while ((sbq.size() != 0 || busy) && guard < 100) begin
      @(negedge clk);
      guard++;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired: actual=hung expected=complete");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(done === 1'b0, "R1", "done at reset", 64'(done), 64'd0);
    check(busy === 1'b0, "R1", "busy at reset", 64'(busy), 64'd0);
    check(product === 64'd0, "R1", "product at reset", product, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    monOn = 1;

    // R3 / R4 basic patterns
    doOp(32'd7, 32'd0, "R4 zero multiplier");
    doOp(32'd7, 32'd6, "R3 small");
    doOp(32'hFFFF_FFF9, 32'd13, "R3 neg mcand");
    doOp(32'd123456, 32'h7FFF_FFFF, "R4 all low rows");
    doOp(32'd5, 32'hFFFF_FFFF, "R4 minus one");
    // R6 sign row and extreme values
    doOp(32'h8000_0000, 32'h8000_0000, "R6 minneg squared");
    doOp(32'h8000_0000, 32'hFFFF_FFFF, "R6 minneg times -1");
    doOp(32'hFFFF_FFFF, 32'h8000_0000, "R6 -1 times minneg");
    doOp(32'h7FFF_FFFF, 32'h8000_0001, "R6 maxpos times near minneg");
    doOp(32'd0, 32'hFFFF_FFFF, "R3 zero mcand");
    drain();

    // R7 back-to-back: each start lands in the done cycle of the previous op
    doOp(32'd3, 32'd1, "R7 chain a");
    doOp(32'hFFFF_0000, 32'hFFFF_FFFE, "R7 chain b");
    doOp(32'd9, 32'd0, "R7 chain c");
    doOp(32'h1234_5678, 32'h8765_4321, "R7 chain d");
    drain();

    // R2 start while busy is ignored
    doOp(32'd11, 32'hFFFF_FFFF, "R2 running op");
    repeat (4) @(negedge clk);
    mcand = 32'd99; mplier = 32'd2; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    drain();
    check(sbq.size() == 0, "R2", "queue drained", 64'(sbq.size()), 64'd0);

    // R3 random mix with short and full effective lengths
    for (int i = 0; i < 150; i++) begin
      logic [W-1:0] a, b;
      a = $urandom;
      b = $urandom;
      if (i % 3 == 0) b = b & 32'h0000_01FF;
      if (i % 5 == 0) a = {{24{a[7]}}, a[7:0]};
      if (i % 7 == 0) b = {{24{b[7]}}, b[7:0]};
      doOp(a, b, "R3 random");
    end
    drain();
    finish();
  end
endmodule